// File: doc/BRIEF.md
# SDRAM Command Legality Monitor

This block watches the control lines of a two-bank (by default) SDRAM as a memory controller drives them. On every rising clock edge it turns chip select, row strobe, column strobe and write enable into one command. It tracks whether each bank is open. It also tracks whether the whole device is in its normal state, busy with a refresh, or busy with a mode register load. Each command is judged against that state and against a set of minimum gaps that are counted in clock cycles.

Every judgement is reported one clock after the command is sampled, on two flags. One flag marks a command that the present state does not allow. The other marks a command that would be allowed, but comes too soon. A command that raises either flag is treated as if it never happened, so one controller fault does not corrupt the rest of the trace. The block is intended for simulation monitors and on-chip protocol watchdogs that sit beside an SDRAM controller.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: The command sampled at a clock edge appears on `cmd_code` after that edge. The codes are: deselect 0 (chip select high), NOP 1 (row/col/we = 111), mode load 2 (000), refresh 3 (001), precharge 4 (010), activate 5 (011), write 7 (100), read 6 (101), burst stop 8 (110).
- R2: After reset, `cmd_code` is 0, all banks are idle, `dev_state` is 0 (normal) and both flags are low.
- R3: A refresh is legal only when the device is in its normal state and every bank is idle. The device then reports `dev_state` 1 for the next T_RC-1 samples and is back to normal for the command T_RC cycles after the refresh. While it is refreshing, any command other than NOP or deselect raises `err_state`.
- R4: A mode load has the same legality condition as refresh. The device reports `dev_state` 2 for exactly one cycle. Any command other than NOP or deselect during that cycle raises `err_state`.
- R5: An activate to an idle bank opens it. An activate to an open bank raises `err_state`.
- R6: An activate issued fewer than T_RRD cycles after the previous accepted activate to any bank raises `err_timing`.
- R7: A read or write to an idle bank raises `err_state`. A read or write issued fewer than T_RCD cycles after that bank's activate raises `err_timing`.
- R8: An accepted read or write with A10 high closes its bank. With A10 low, the bank stays open.
- R9: A precharge to an open bank fewer than T_RAS cycles after its activate raises `err_timing`. Otherwise a precharge closes the addressed bank. A precharge to an idle bank is legal and changes nothing, and A10 has no effect on a precharge.
- R10: The legality of a bank command depends only on the addressed bank, apart from the device-wide T_RRD gap. A bank can be opened or used while another bank is open.
- R11: A command that raises a flag leaves the bank and device state unchanged. `err_state` and `err_timing` are never high together; when a state error applies, it takes precedence.
- R12: NOP, deselect and, in the normal state, burst stop are legal and change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W | Bank address |
| a10 | input | 1 | Auto-precharge select on read/write |
| cmd_code | output | 4 | Last decoded command |
| bank_active | output | NUM_BANKS | One bit per bank, 1 = open |
| dev_state | output | 2 | 0 normal, 1 refreshing, 2 mode load |
| err_state | output | 1 | Last command illegal for the state |
| err_timing | output | 1 | Last command broke a cycle gap |

## Verification
The hardest case to reach is a command that lands exactly on the boundary of a gap. Examples are a read in the very cycle that T_RCD expires, or the first command after a refresh window ends. Such a boundary can also be crossed while another bank is open, or while an earlier faulty command was being ignored. Directed sequences pad with NOPs to step across each boundary one cycle at a time. A long run of random commands, banks and A10 values then produces interleavings that no directed list covers. A timestamp-based reference model checks every cycle of that run.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;

   typedef enum logic [3:0] {
      CMD_DESEL = 4'd0,
      CMD_NOP   = 4'd1,
      CMD_MRS   = 4'd2,
      CMD_REF   = 4'd3,
      CMD_PRE   = 4'd4,
      CMD_ACT   = 4'd5,
      CMD_RD    = 4'd6,
      CMD_WR    = 4'd7,
      CMD_BST   = 4'd8
   } cmd_e;

   typedef enum logic [1:0] {
      DEV_NORM = 2'd0,
      DEV_REF  = 2'd1,
      DEV_MRS  = 2'd2
   } dev_mode_e;

   localparam int unsigned T_MRD = 2;

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
   import sdram_mon_pkg::*;
(
   input  logic cs_n,
   input  logic ras_n,
   input  logic cas_n,
   input  logic we_n,
   output cmd_e cmd
);
   always_comb begin
      if (cs_n) begin
         cmd = CMD_DESEL;
      end else begin
         case ({ras_n, cas_n, we_n})
            3'b000:  cmd = CMD_MRS;
            3'b001:  cmd = CMD_REF;
            3'b010:  cmd = CMD_PRE;
            3'b011:  cmd = CMD_ACT;
            3'b100:  cmd = CMD_WR;
            3'b101:  cmd = CMD_RD;
            3'b110:  cmd = CMD_BST;
            default: cmd = CMD_NOP;
         endcase
      end
   end
endmodule

// File: rtl/sdram_gap_timer.sv
module sdram_gap_timer #(
   parameter int unsigned LIMIT = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic done
);
   localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
   localparam logic [CW-1:0] RELOAD = CW'(LIMIT - 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= RELOAD;
      end else if (cnt != '0) begin
         cnt <= cnt - 1'b1;
      end
   end

   assign done = (cnt == '0);
endmodule

// File: rtl/sdram_bank_track.sv
module sdram_bank_track #(
   parameter int unsigned T_RCD = 3,
   parameter int unsigned T_RAS = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic act_go,
   input  logic rw_go,
   input  logic rw_ap,
   input  logic pre_go,
   output logic active,
   output logic rcd_ok,
   output logic ras_ok
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active <= 1'b0;
      end else if (act_go) begin
         active <= 1'b1;
      end else if (pre_go || (rw_go && rw_ap)) begin
         active <= 1'b0;
      end
   end

   sdram_gap_timer #(.LIMIT(T_RCD)) u_rcd (
      .clk(clk), .rst_n(rst_n), .load(act_go), .done(rcd_ok)
   );

   sdram_gap_timer #(.LIMIT(T_RAS)) u_ras (
      .clk(clk), .rst_n(rst_n), .load(act_go), .done(ras_ok)
   );
endmodule

// File: rtl/sdram_dev_track.sv
module sdram_dev_track
   import sdram_mon_pkg::*;
#(
   parameter int unsigned T_RC  = 6,
   parameter int unsigned T_RRD = 2
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      ref_go,
   input  logic      mrs_go,
   input  logic      act_go,
   output dev_mode_e mode,
   output logic      rrd_ok
);
   localparam int unsigned BUSY_MAX = (T_RC > T_MRD) ? T_RC : T_MRD;
   localparam int unsigned CW       = $clog2(BUSY_MAX);

   logic [CW-1:0] busy_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode     <= DEV_NORM;
         busy_cnt <= '0;
      end else if (ref_go) begin
         mode     <= DEV_REF;
         busy_cnt <= CW'(T_RC - 1);
      end else if (mrs_go) begin
         mode     <= DEV_MRS;
         busy_cnt <= CW'(T_MRD - 1);
      end else if (mode != DEV_NORM) begin
         if (busy_cnt <= CW'(1)) begin
            mode     <= DEV_NORM;
            busy_cnt <= '0;
         end else begin
            busy_cnt <= busy_cnt - 1'b1;
         end
      end
   end

   sdram_gap_timer #(.LIMIT(T_RRD)) u_rrd (
      .clk(clk), .rst_n(rst_n), .load(act_go), .done(rrd_ok)
   );
endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
   import sdram_mon_pkg::*;
#(
   parameter int unsigned NUM_BANKS = 2,
   parameter int unsigned T_RC      = 6,
   parameter int unsigned T_RCD     = 3,
   parameter int unsigned T_RRD     = 2,
   parameter int unsigned T_RAS     = 5,
   localparam int unsigned BA_W     = $clog2(NUM_BANKS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cs_n,
   input  logic                 ras_n,
   input  logic                 cas_n,
   input  logic                 we_n,
   input  logic [BA_W-1:0]      ba,
   input  logic                 a10,
   output logic [3:0]           cmd_code,
   output logic [NUM_BANKS-1:0] bank_active,
   output logic [1:0]           dev_state,
   output logic                 err_state,
   output logic                 err_timing
);
   if (NUM_BANKS < 2 || (NUM_BANKS & (NUM_BANKS - 1)) != 0) begin : g_bad_banks
      $error("NUM_BANKS must be a power of two, at least 2");
   end
   if (T_RC < 2) begin : g_bad_rc
      $error("T_RC must be at least 2");
   end
   if (T_RCD < 1 || T_RRD < 1 || T_RAS < 1) begin : g_bad_gap
      $error("gap parameters must be at least 1");
   end

   cmd_e                 cmd_now;
   dev_mode_e            mode;
   logic                 rrd_ok;
   logic [NUM_BANKS-1:0] act_v, rcd_ok_v, ras_ok_v;
   logic [NUM_BANKS-1:0] act_go_v, rw_go_v, pre_go_v;
   logic                 st_bad, tm_bad, tm_eff, cmd_ok;
   logic                 tgt_act, tgt_rcd, tgt_ras, dev_norm, all_idle;

   sdram_cmd_decode u_dec (
      .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cmd(cmd_now)
   );

   assign dev_norm = (mode == DEV_NORM);
   assign all_idle = (act_v == '0);
   assign tgt_act  = act_v[ba];
   assign tgt_rcd  = rcd_ok_v[ba];
   assign tgt_ras  = ras_ok_v[ba];

   always_comb begin
      st_bad = 1'b0;
      tm_bad = 1'b0;
      case (cmd_now)
         CMD_MRS, CMD_REF: st_bad = !dev_norm || !all_idle;
         CMD_ACT: begin
            st_bad = !dev_norm || tgt_act;
            tm_bad = !rrd_ok;
         end
         CMD_RD, CMD_WR: begin
            st_bad = !dev_norm || !tgt_act;
            tm_bad = !tgt_rcd;
         end
         CMD_PRE: begin
            st_bad = !dev_norm;
            tm_bad = tgt_act && !tgt_ras;
         end
         CMD_BST: st_bad = !dev_norm;
         default: begin
            st_bad = 1'b0;
            tm_bad = 1'b0;
         end
      endcase
   end

   assign tm_eff = tm_bad && !st_bad;
   assign cmd_ok = !st_bad && !tm_bad;

   for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
      logic hit;
      assign hit         = (ba == BA_W'(g));
      assign act_go_v[g] = cmd_ok && hit && (cmd_now == CMD_ACT);
      assign rw_go_v[g]  = cmd_ok && hit && (cmd_now == CMD_RD || cmd_now == CMD_WR);
      assign pre_go_v[g] = cmd_ok && hit && (cmd_now == CMD_PRE);

      sdram_bank_track #(.T_RCD(T_RCD), .T_RAS(T_RAS)) u_bank (
         .clk(clk), .rst_n(rst_n),
         .act_go(act_go_v[g]), .rw_go(rw_go_v[g]), .rw_ap(a10),
         .pre_go(pre_go_v[g]),
         .active(act_v[g]), .rcd_ok(rcd_ok_v[g]), .ras_ok(ras_ok_v[g])
      );
   end

   sdram_dev_track #(.T_RC(T_RC), .T_RRD(T_RRD)) u_dev (
      .clk(clk), .rst_n(rst_n),
      .ref_go(cmd_ok && cmd_now == CMD_REF),
      .mrs_go(cmd_ok && cmd_now == CMD_MRS),
      .act_go(|act_go_v),
      .mode(mode), .rrd_ok(rrd_ok)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_code   <= CMD_DESEL;
         err_state  <= 1'b0;
         err_timing <= 1'b0;
      end else begin
         cmd_code   <= cmd_now;
         err_state  <= st_bad;
         err_timing <= tm_eff;
      end
   end

   assign bank_active = act_v;
   assign dev_state   = mode;
endmodule

// File: rtl/sdram_mon_chk.sv
module sdram_mon_chk #(
   parameter int unsigned NUM_BANKS = 2,
   localparam int unsigned BA_W     = $clog2(NUM_BANKS)
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [BA_W-1:0]      ba,
   input logic [3:0]           cmd_code,
   input logic [NUM_BANKS-1:0] bank_active,
   input logic [1:0]           dev_state,
   input logic                 err_state,
   input logic                 err_timing
);
   // R11
   flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(err_state && err_timing));

   // R11
   flagged_no_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err_state || err_timing) |-> bank_active == $past(bank_active));

   // R4
   mrs_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_state == 2'd2) |=> (dev_state == 2'd0));

   // R3
   busy_banks_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_state != 2'd0) |-> (bank_active == '0));

   // R5
   act_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_code == 4'd5 && !err_state && !err_timing) |-> bank_active[$past(ba)]);

   // R3
   ref_enters_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_code == 4'd3 && !err_state) |-> (dev_state == 2'd1));
endmodule

bind sdram_cmd_monitor sdram_mon_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
   .clk(clk), .rst_n(rst_n), .ba(ba), .cmd_code(cmd_code),
   .bank_active(bank_active), .dev_state(dev_state),
   .err_state(err_state), .err_timing(err_timing)
);

// File: tb/tb_sdram_cmd_monitor.sv
module tb_sdram_cmd_monitor;
   localparam int NB = 2, TRC = 6, TRCD = 3, TRRD = 2, TRAS = 5;
   localparam int DES = 0, NOP = 1, MRS = 2, REF = 3, PRE = 4, ACT = 5,
                  RD = 6, WR = 7, BST = 8;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, a10 = 1'b0;
   logic [0:0] ba = '0;
   logic [3:0] cmd_code;
   logic [NB-1:0] bank_active;
   logic [1:0] dev_state;
   logic err_state, err_timing;

   sdram_cmd_monitor #(.NUM_BANKS(NB), .T_RC(TRC), .T_RCD(TRCD),
                       .T_RRD(TRRD), .T_RAS(TRAS)) dut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
      .we_n(we_n), .ba(ba), .a10(a10), .cmd_code(cmd_code),
      .bank_active(bank_active), .dev_state(dev_state),
      .err_state(err_state), .err_timing(err_timing)
   );

   always #4 clk = ~clk;

   int total = 0, bad = 0;
   bit done = 0;
   string cur_req = "R2";

   // reference model state
   int cyc = 0, last_act = -1000, ref_end = -1000, mrs_end = -1000;
   int act_at[NB];
   bit m_open[NB];
   int e_cmd = 0, e_dev = 0, e_es = 0, e_et = 0;

   task automatic chk(input string tag, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d at cyc %0d", tag, what, act, exp, cyc);
      end
   endtask

   task automatic compare();
      int bits = 0;
      for (int i = 0; i < NB; i++) bits |= (m_open[i] ? 1 : 0) << i;
      chk("R1", "cmd_code", int'(cmd_code), e_cmd);
      chk(cur_req, "bank_active", int'(bank_active), bits);
      chk(cur_req, "dev_state", int'(dev_state), e_dev);
      chk(cur_req, "err_state", int'(err_state), e_es);
      chk(cur_req, "err_timing", int'(err_timing), e_et);
   endtask

   task automatic model(input int code, input int b, input bit ap);
      int busy;
      bit all_idle, st, tm;
      busy = (cyc < ref_end) ? 1 : ((cyc < mrs_end) ? 2 : 0);
      all_idle = 1;
      for (int i = 0; i < NB; i++) if (m_open[i]) all_idle = 0;
      st = 0; tm = 0;
      if (code == MRS || code == REF) st = (busy != 0) || !all_idle;
      else if (code == ACT) begin
         st = (busy != 0) || m_open[b];
         tm = (cyc - last_act) < TRRD;
      end else if (code == RD || code == WR) begin
         st = (busy != 0) || !m_open[b];
         tm = (cyc - act_at[b]) < TRCD;
      end else if (code == PRE) begin
         st = (busy != 0);
         tm = m_open[b] && ((cyc - act_at[b]) < TRAS);
      end else if (code == BST) st = (busy != 0);
      if (!st && !tm) begin
         case (code)
            ACT: begin m_open[b] = 1; act_at[b] = cyc; last_act = cyc; end
            RD, WR: if (ap) m_open[b] = 0;
            PRE: m_open[b] = 0;
            REF: ref_end = cyc + TRC;
            MRS: mrs_end = cyc + 2;
            default: ;
         endcase
      end
      e_cmd = code;
      e_es = st;
      e_et = (tm && !st) ? 1 : 0;
      e_dev = (cyc + 1 < ref_end) ? 1 : ((cyc + 1 < mrs_end) ? 2 : 0);
      cyc++;
   endtask

   task automatic step(input int code, input int b = 0, input bit ap = 0);
      @(negedge clk);
      compare();
      cs_n = (code == DES);
      case (code)
         MRS: {ras_n, cas_n, we_n} = 3'b000;
         REF: {ras_n, cas_n, we_n} = 3'b001;
         PRE: {ras_n, cas_n, we_n} = 3'b010;
         ACT: {ras_n, cas_n, we_n} = 3'b011;
         WR:  {ras_n, cas_n, we_n} = 3'b100;
         RD:  {ras_n, cas_n, we_n} = 3'b101;
         BST: {ras_n, cas_n, we_n} = 3'b110;
         default: {ras_n, cas_n, we_n} = 3'b111;
      endcase
      ba = b[0:0];
      a10 = ap;
      @(posedge clk);
      model(code, b, ap);
   endtask

   task automatic nops(input int n);
      for (int i = 0; i < n; i++) step(NOP);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      for (int i = 0; i < NB; i++) begin act_at[i] = -1000; m_open[i] = 0; end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R2: reset values
      chk("R2", "cmd_code", int'(cmd_code), 0);
      chk("R2", "bank_active", int'(bank_active), 0);
      chk("R2", "dev_state", int'(dev_state), 0);
      chk("R2", "err_state", int'(err_state), 0);
      chk("R2", "err_timing", int'(err_timing), 0);

      cur_req = "R12"; step(NOP); step(DES); step(BST); step(NOP);
      cur_req = "R4";  step(MRS); step(ACT, 0); step(NOP); step(MRS); step(NOP); step(NOP);
      cur_req = "R3";  step(REF); step(RD, 0); step(BST); nops(2); step(MRS); step(ACT, 1); step(NOP);
      cur_req = "R5";  step(ACT, 0); step(NOP); step(NOP); step(ACT, 0);
      cur_req = "R3";  step(REF); step(MRS); nops(2);
      cur_req = "R6";  step(ACT, 1); step(PRE, 1); nops(2);
      cur_req = "R9";  step(PRE, 1, 1); step(PRE, 0, 1); step(PRE, 1); step(NOP);
      cur_req = "R6";  step(ACT, 0); step(ACT, 1); step(ACT, 1); nops(2);
      cur_req = "R10"; step(RD, 0); step(WR, 1); nops(3);
      cur_req = "R7";  step(PRE, 0); step(RD, 0); step(ACT, 0); step(RD, 0); step(WR, 0);
                       step(RD, 0); step(NOP);
      cur_req = "R8";  step(WR, 0, 0); step(RD, 0, 1); step(RD, 0); step(WR, 1, 1); step(NOP);
      cur_req = "R11"; step(ACT, 1); step(PRE, 1); step(ACT, 1); step(REF); nops(6);
      cur_req = "R9";  step(PRE, 1); step(NOP);
      cur_req = "R10";
      for (int i = 0; i < 1500; i++) begin
         int c;
         c = $urandom_range(0, 11);
         if (c > 8) c = NOP;
         if (c == REF && $urandom_range(0, 3) != 0) c = PRE;
         step(c, $urandom_range(0, NB - 1), 1'($urandom_range(0, 1)));
      end
      @(negedge clk);
      compare();
      finish_run();
   end

   initial begin
      repeat (50000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog run did not complete actual=hung expected=done");
      finish_run();
   end
endmodule